// File: doc/BRIEF.md
# Cascade Master/Slave Acknowledge Logic

This block is the acknowledge and vectoring stage of an eight-level interrupt controller. It is written so that several copies can share one processor interrupt line. A strap input gives each copy its role. One copy acts as master. The interrupt outputs of up to eight slave copies feed request inputs of the master, which gives at most 64 levels.

When the processor acknowledges a request, it issues two acknowledge strobes. On the first strobe the master picks the winning level and marks it in service. If that level has a slave attached, the master broadcasts the level number on a 3-bit cascade bus until the second strobe ends. Otherwise the master answers the vector phase itself. A slave compares the cascade bus with its configured identity on the first strobe. On a match it takes its own winning level into service and drives the vector byte after the second strobe. A slave that does not match stays silent.

The remaining controller core is also here. It holds a request register with edge or level capture, a mask, fixed priority with level 0 highest, and an in-service register. Each bit of the in-service register is cleared either by a non-specific end-of-interrupt strobe or automatically at the second acknowledge.

Top module: `cascade_ack_ctrl`

## Requirements
- R1: While reset is held low, and in the first cycle after it, `int_o`, `vec_oe` and `cas_oe` are low, and all request and in-service bits are clear.
- R2: Among pending unmasked requests (mask bit 1 = masked), the lowest index wins. One cycle after the clock edge that samples the second acknowledge strobe, `vec_oe` is high for exactly one cycle, and `vec_o` = {`cfg_base`, winning level in the low 3 bits}.
- R3: `int_o` is asserted only if a pending unmasked request has a lower index than the lowest in-service bit. A request at or below that priority does not raise `int_o`.
- R4: On a master (`is_master`=1), a winning level whose `cfg_slave_map` bit is 1 makes `cas_oe` high with `cas_o` = the level number. This lasts from the first acknowledge strobe through the second, with `cas_o` stable. The master then does not assert `vec_oe` for that sequence.
- R5: On a master, a winning level whose `cfg_slave_map` bit is 0 leaves `cas_oe` low, and the master itself supplies the vector.
- R6: On a slave, if `cas_i` equals `cfg_id` during the first strobe, the slave's winning level is taken into service: its request clears and `int_o` drops. The slave then drives the vector after the second strobe.
- R7: On a slave whose `cfg_id` differs from `cas_i`, `vec_oe` stays low for the whole sequence and its request stays pending.
- R8: A slave (`is_master`=0) never asserts `cas_oe`.
- R9: With `cfg_aeoi`=1, the in-service bit taken at the first strobe is cleared at the second strobe.
- R10: An `eoi_i` strobe clears only the lowest-index (highest-priority) in-service bit.
- R11: An acknowledge with no eligible winning request returns the level-7 vector and leaves the in-service register unchanged.
- R12: With `cfg_level`=1 a request follows the input level. With `cfg_level`=0 only a 0-to-1 transition sets it, so a request held high after service does not request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | Role strap, 1 = master, 0 = slave |
| cfg_level | input | 1 | 1 = level-captured requests, 0 = rising-edge captured |
| cfg_aeoi | input | 1 | Automatic end of interrupt at second acknowledge |
| cfg_mask | input | 8 | Per-level mask, 1 blocks the level |
| cfg_slave_map | input | 8 | Master only: levels that have a slave attached |
| cfg_id | input | 3 | Slave only: identity compared with the cascade bus |
| cfg_base | input | 5 | Upper bits of the vector byte |
| irq_i | input | 8 | Interrupt request inputs |
| int_o | output | 1 | Interrupt to processor or to master |
| ack_i | input | 1 | One-cycle acknowledge strobe, issued twice per sequence |
| eoi_i | input | 1 | One-cycle non-specific end-of-interrupt strobe |
| cas_i | input | 3 | Cascade address input (used by slaves) |
| cas_o | output | 3 | Cascade address output (master) |
| cas_oe | output | 1 | Cascade address output enable |
| vec_o | output | 8 | Vector byte |
| vec_oe | output | 1 | Vector byte enable |

## Verification
Some rules are checked on every cycle: a slave never enables the cascade bus, the cascade address only comes up with an acknowledge strobe and stays stable while it is driven, the vector enable is a single-cycle pulse after a strobe, and a master that broadcast an address does not also supply a vector. Other behaviour can only be shown by the bench scenarios: the vector value, the choice of which in-service bit an end-of-interrupt clears, nesting under in-service levels, identity matching between a real master and slave pair, spurious acknowledges, and the edge versus level capture rule.

// File: rtl/cas_ack_pkg.sv
package cas_ack_pkg;
    // Acknowledge sequence phase: waiting for the first or the second strobe.
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } ack_phase_e;
endpackage

// File: rtl/cas_first_set.sv
// cas_first_set: finds the lowest-index set bit of a vector.
// Assumes N is a power of two; idx_o is zero when no bit is set.
module cas_first_set #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic          any_o,
    output logic [LW-1:0] idx_o,
    output logic [N-1:0]  onehot_o
);
    // Scan from the top so the lowest set bit is the last one written.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = LW'(i);
        end
    end

    // Isolate the lowest set bit with a two's complement trick.
    always_comb begin
        any_o    = |vec_i;
        onehot_o = vec_i & (~vec_i + N'(1));
    end
endmodule

// File: rtl/cas_req_reg.sv
// cas_req_reg: request capture register, level or rising-edge mode.
// Assumes irq_i is already synchronous to clk. A clear from the
// acknowledge logic wins over a new capture in the same cycle.
module cas_req_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         level_mode_i,
    input  logic [N-1:0] irq_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] irr_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise;

    // Rising transitions relative to the previous cycle.
    always_comb rise = irq_i & ~prev_q;

    // Track previous input and update the request bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_o  <= '0;
        end else begin
            prev_q <= irq_i;
            if (level_mode_i) irr_o <= irq_i & ~clr_i;
            else              irr_o <= (irr_o | rise) & ~clr_i;
        end
    end
endmodule

// File: rtl/cas_prio.sv
// cas_prio: fixed-priority resolver, level 0 highest. A request wins only
// if it is unmasked and outranks every level currently in service.
module cas_prio #(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  irr_i,
    input  logic [N-1:0]  mask_i,
    input  logic [N-1:0]  isr_i,
    output logic          win_valid_o,
    output logic [LW-1:0] win_lvl_o
);
    logic [N-1:0]  elig;
    logic [N-1:0]  above;
    logic          isr_any;
    logic [LW-1:0] isr_idx;
    logic [N-1:0]  isr_low;
    logic          req_any;
    logic [N-1:0]  req_low;

    cas_first_set #(.N(N), .LW(LW)) u_isr_find (
        .vec_i   (isr_i),
        .any_o   (isr_any),
        .idx_o   (isr_idx),
        .onehot_o(isr_low)
    );

    // Levels that outrank the highest-priority in-service level.
    always_comb begin
        above = isr_any ? (isr_low - N'(1)) : '1;
        elig  = irr_i & ~mask_i & above;
    end

    cas_first_set #(.N(N), .LW(LW)) u_req_find (
        .vec_i   (elig),
        .any_o   (req_any),
        .idx_o   (win_lvl_o),
        .onehot_o(req_low)
    );

    // Winner exists when any eligible request remains.
    always_comb win_valid_o = req_any;

    logic unused_ok;
    always_comb unused_ok = ^{isr_idx, req_low};
endmodule

// File: rtl/cas_ack_seq.sv
// cas_ack_seq: two-strobe acknowledge sequencer with cascade handling.
// Owns the in-service register. Master: broadcasts the level on the
// cascade bus when that level has a slave attached, else vectors itself.
// Slave: matches the cascade bus against its identity on the first
// strobe. Assumes the two strobes are separated by at least one idle cycle.
module cas_ack_seq
    import cas_ack_pkg::*;
#(
    parameter int N     = 8,
    parameter int LW    = $clog2(N),
    parameter int VEC_W = 8,
    parameter int BW    = VEC_W - LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_master,
    input  logic          ack_i,
    input  logic          eoi_i,
    input  logic          aeoi_i,
    input  logic [N-1:0]  slave_map_i,
    input  logic [LW-1:0] id_i,
    input  logic [BW-1:0] base_i,
    input  logic [LW-1:0] cas_i,
    input  logic          win_valid_i,
    input  logic [LW-1:0] win_lvl_i,
    output logic [N-1:0]  isr_o,
    output logic [N-1:0]  irr_clr_o,
    output logic [LW-1:0] cas_o,
    output logic          cas_oe_o,
    output logic [VEC_W-1:0] vec_o,
    output logic          vec_oe_o
);
    ack_phase_e       phase_q;
    logic [LW-1:0]    lvl_q;
    logic             own_q;
    logic             resp_q;
    logic             cdrv_q;
    logic [VEC_W-1:0] vec_q;
    logic             first_ack;
    logic             second_ack;
    logic             to_slave;
    logic             id_match;
    logic             accept;
    logic             resp_n;
    logic [N-1:0]     win_oh;
    logic [N-1:0]     lvl_oh;
    logic [N-1:0]     set_v;
    logic [N-1:0]     clr_auto;
    logic [N-1:0]     clr_cmd;
    logic             isr_any;
    logic [LW-1:0]    isr_idx;
    logic [N-1:0]     isr_low;

    // Strobe qualification and role-dependent decisions.
    always_comb begin
        first_ack  = ack_i && (phase_q == PH_FIRST);
        second_ack = ack_i && (phase_q == PH_SECOND);
        to_slave   = win_valid_i && slave_map_i[win_lvl_i];
        id_match   = (cas_i == id_i);
        accept     = first_ack && win_valid_i && (is_master || id_match);
        resp_n     = is_master ? !to_slave : id_match;
        win_oh     = {{(N-1){1'b0}}, 1'b1} << win_lvl_i;
        lvl_oh     = {{(N-1){1'b0}}, 1'b1} << lvl_q;
    end

    cas_first_set #(.N(N), .LW(LW)) u_eoi_find (
        .vec_i   (isr_o),
        .any_o   (isr_any),
        .idx_o   (isr_idx),
        .onehot_o(isr_low)
    );

    // In-service set and clear terms.
    always_comb begin
        set_v     = accept ? win_oh : '0;
        clr_auto  = (second_ack && aeoi_i && own_q) ? lvl_oh : '0;
        clr_cmd   = eoi_i ? isr_low : '0;
        irr_clr_o = set_v;
    end

    // Phase, captured level and responder flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FIRST;
            lvl_q   <= '0;
            own_q   <= 1'b0;
            resp_q  <= 1'b0;
            cdrv_q  <= 1'b0;
        end else if (first_ack) begin
            phase_q <= PH_SECOND;
            lvl_q   <= win_valid_i ? win_lvl_i : '1;
            own_q   <= accept;
            resp_q  <= resp_n;
            cdrv_q  <= is_master && to_slave;
        end else if (second_ack) begin
            phase_q <= PH_FIRST;
            own_q   <= 1'b0;
            resp_q  <= 1'b0;
            cdrv_q  <= 1'b0;
        end
    end

    // In-service register update.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_o <= '0;
        else        isr_o <= (isr_o | set_v) & ~clr_auto & ~clr_cmd;
    end

    // Vector byte, presented for one cycle after the second strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q    <= '0;
            vec_oe_o <= 1'b0;
        end else begin
            vec_oe_o <= second_ack && resp_q;
            if (second_ack) vec_q <= {base_i, lvl_q};
        end
    end

    // Cascade address drive, master role only.
    always_comb begin
        cas_oe_o = is_master &&
                   ((first_ack && to_slave) || (phase_q == PH_SECOND && cdrv_q));
        if (!cas_oe_o)                 cas_o = '0;
        else if (phase_q == PH_FIRST)  cas_o = win_lvl_i;
        else                           cas_o = lvl_q;
        vec_o = vec_oe_o ? vec_q : '0;
    end

    logic unused_ok;
    always_comb unused_ok = ^{isr_any, isr_idx};
endmodule

// File: rtl/cascade_ack_ctrl.sv
// cascade_ack_ctrl: interrupt controller core with cascade acknowledge.
// Assumes all inputs are synchronous to clk, ack_i and eoi_i are one-cycle
// strobes, and the two acknowledge strobes are at least two cycles apart.
module cascade_ack_ctrl #(
    parameter int N_LVL = 8,
    parameter int VEC_W = 8,
    localparam int LW   = $clog2(N_LVL),
    localparam int BW   = VEC_W - LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             cfg_level,
    input  logic             cfg_aeoi,
    input  logic [N_LVL-1:0] cfg_mask,
    input  logic [N_LVL-1:0] cfg_slave_map,
    input  logic [LW-1:0]    cfg_id,
    input  logic [BW-1:0]    cfg_base,
    input  logic [N_LVL-1:0] irq_i,
    output logic             int_o,
    input  logic             ack_i,
    input  logic             eoi_i,
    input  logic [LW-1:0]    cas_i,
    output logic [LW-1:0]    cas_o,
    output logic             cas_oe,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_oe
);
    logic [N_LVL-1:0] irr;
    logic [N_LVL-1:0] isr;
    logic [N_LVL-1:0] irr_clr;
    logic             win_valid;
    logic [LW-1:0]    win_lvl;

    cas_req_reg #(.N(N_LVL)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .level_mode_i(cfg_level),
        .irq_i       (irq_i),
        .clr_i       (irr_clr),
        .irr_o       (irr)
    );

    cas_prio #(.N(N_LVL), .LW(LW)) u_prio (
        .irr_i      (irr),
        .mask_i     (cfg_mask),
        .isr_i      (isr),
        .win_valid_o(win_valid),
        .win_lvl_o  (win_lvl)
    );

    cas_ack_seq #(.N(N_LVL), .LW(LW), .VEC_W(VEC_W), .BW(BW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_master  (is_master),
        .ack_i      (ack_i),
        .eoi_i      (eoi_i),
        .aeoi_i     (cfg_aeoi),
        .slave_map_i(cfg_slave_map),
        .id_i       (cfg_id),
        .base_i     (cfg_base),
        .cas_i      (cas_i),
        .win_valid_i(win_valid),
        .win_lvl_i  (win_lvl),
        .isr_o      (isr),
        .irr_clr_o  (irr_clr),
        .cas_o      (cas_o),
        .cas_oe_o   (cas_oe),
        .vec_o      (vec_o),
        .vec_oe_o   (vec_oe)
    );

    // Interrupt output follows the resolver.
    always_comb int_o = win_valid;
endmodule

// File: rtl/cascade_ack_chk.sv
// cascade_ack_chk: protocol properties on the ports of cascade_ack_ctrl.
module cascade_ack_chk #(
    parameter int LW    = 3,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             is_master,
    input logic             ack_i,
    input logic             int_o,
    input logic [LW-1:0]    cas_o,
    input logic             cas_oe,
    input logic [VEC_W-1:0] vec_o,
    input logic             vec_oe
);
    // R1: reset leaves the outputs quiet in the following cycle.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!vec_oe && !int_o));

    // R2: vector enable is a single-cycle pulse.
    a_r2_vec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |=> !vec_oe);

    // R2: vector enable rises only after an acknowledge strobe.
    a_r2_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_oe) |-> $past(ack_i));

    // R4: cascade drive starts with an acknowledge strobe.
    a_r4_cas_starts_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_oe) |-> ack_i);

    // R4: cascade address is stable while it is driven.
    a_r4_cas_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_oe && $past(cas_oe)) |-> $stable(cas_o));

    // R4: a master that broadcast an address does not vector itself.
    a_r4_master_no_vec_when_cascaded: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && vec_oe) |-> !$past(cas_oe));

    // R8: a slave never drives the cascade bus.
    a_r8_slave_no_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> !cas_oe);

    logic unused_ok;
    always_comb unused_ok = ^vec_o;
endmodule

bind cascade_ack_ctrl cascade_ack_chk #(.LW(LW), .VEC_W(VEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_master(is_master),
    .ack_i    (ack_i),
    .int_o    (int_o),
    .cas_o    (cas_o),
    .cas_oe   (cas_oe),
    .vec_o    (vec_o),
    .vec_oe   (vec_oe)
);

// File: tb/sim_cascade_ack_ctrl.sv
module sim_cascade_ack_ctrl;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       ack = 1'b0;
    // master configuration and stimulus
    logic       m_level = 1'b1, m_aeoi = 1'b0, m_eoi = 1'b0;
    logic [7:0] m_mask = 8'h00, m_map = 8'h08, m_ext = 8'h00;
    // slave configuration and stimulus
    logic       s_level = 1'b1, s_aeoi = 1'b0, s_eoi = 1'b0;
    logic [7:0] s_mask = 8'h00, s_irq = 8'h00;
    logic [2:0] s_id = 3'd3;

    logic       m_int, s_int, m_cas_oe, s_cas_oe, m_voe, s_voe;
    logic [2:0] m_cas, s_cas;
    logic [7:0] m_vec, s_vec, m_irq;

    always_comb m_irq = {m_ext[7:4], s_int, m_ext[2:0]};

    cascade_ack_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .is_master(1'b1), .cfg_level(m_level),
        .cfg_aeoi(m_aeoi), .cfg_mask(m_mask), .cfg_slave_map(m_map),
        .cfg_id(3'd0), .cfg_base(5'h08), .irq_i(m_irq), .int_o(m_int),
        .ack_i(ack), .eoi_i(m_eoi), .cas_i(3'd0), .cas_o(m_cas),
        .cas_oe(m_cas_oe), .vec_o(m_vec), .vec_oe(m_voe)
    );

    cascade_ack_ctrl u1 (
        .clk(clk), .rst_n(rst_n), .is_master(1'b0), .cfg_level(s_level),
        .cfg_aeoi(s_aeoi), .cfg_mask(s_mask), .cfg_slave_map(8'h00),
        .cfg_id(s_id), .cfg_base(5'h10), .irq_i(s_irq), .int_o(s_int),
        .ack_i(ack), .eoi_i(s_eoi), .cas_i(m_cas), .cas_o(s_cas),
        .cas_oe(s_cas_oe), .vec_o(s_vec), .vec_oe(s_voe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // values sampled during an acknowledge sequence
    logic a1_moe, a1_soe, a2_moe, m_voe_r, s_voe_r;
    logic [2:0] a1_mcas, a2_mcas;
    logic [7:0] m_vec_r, s_vec_r;

    task automatic ack_pair();
        @(negedge clk); ack = 1'b1; #1;
        a1_moe = m_cas_oe; a1_mcas = m_cas; a1_soe = s_cas_oe;
        @(negedge clk); ack = 1'b0;
        @(negedge clk); ack = 1'b1; #1;
        a2_moe = m_cas_oe; a2_mcas = m_cas;
        @(negedge clk); ack = 1'b0; #1;
        m_voe_r = m_voe; m_vec_r = m_vec; s_voe_r = s_voe; s_vec_r = s_vec;
    endtask

    task automatic eoi(input logic to_m, input logic to_s);
        @(negedge clk); m_eoi = to_m; s_eoi = to_s;
        @(negedge clk); m_eoi = 1'b0; s_eoi = 1'b0;
    endtask

    // {mask, request, expected int, expected vector}; bit 3 is the slave input
    localparam logic [31:0] TBL [7] = '{
        32'h00_01_01_40, 32'h00_84_01_42, 32'h04_84_01_47, 32'h20_20_00_47,
        32'h00_60_01_45, 32'h00_00_00_47, 32'h00_80_01_47
    };

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cycles(3);
        check("R1 int", int'(m_int), 0);
        check("R1 vec_oe", int'(m_voe), 0);
        check("R1 cas_oe", int'(m_cas_oe), 0);
        @(negedge clk); rst_n = 1'b1;
        cycles(1);
        check("R1 int after reset", int'(m_int), 0);

        // table: R2 priority and mask, R5 local vector, R11 spurious
        foreach (TBL[k]) begin
            @(negedge clk);
            m_mask = TBL[k][31:24]; m_ext = TBL[k][23:16];
            cycles(2);
            check("R2 int", int'(m_int), int'(TBL[k][15:8]));
            ack_pair();
            check("R5 no cas drive", int'(a1_moe), 0);
            check("R2 vec_oe", int'(m_voe_r), 1);
            check("R2/R11 vector", int'(m_vec_r), int'(TBL[k][7:0]));
            m_ext = 8'h00;
            if (TBL[k][8]) eoi(1'b1, 1'b0);
            cycles(2);
        end
        m_mask = 8'h00;

        // R3 nesting and R10 priority of end of interrupt
        @(negedge clk); m_ext = 8'h40; cycles(2);
        ack_pair();
        check("R3 vec lvl6", int'(m_vec_r), 8'h46);
        m_ext = 8'h44; cycles(2);
        check("R3 higher level interrupts", int'(m_int), 1);
        ack_pair();
        check("R3 vec lvl2", int'(m_vec_r), 8'h42);
        m_ext = 8'h10; cycles(2);
        check("R3 lower level blocked", int'(m_int), 0);
        eoi(1'b1, 1'b0); cycles(1);
        check("R10 eoi clears highest", int'(m_int), 1);
        ack_pair();
        check("R10 vec lvl4", int'(m_vec_r), 8'h44);
        m_ext = 8'h00;
        eoi(1'b1, 1'b0); eoi(1'b1, 1'b0); cycles(2);
        check("R10 all cleared", int'(m_int), 0);

        // R4 and R6 cascaded request through matching slave
        s_irq = 8'h20; cycles(3);
        check("R6 master sees slave", int'(m_int), 1);
        ack_pair();
        check("R4 cas_oe first", int'(a1_moe), 1);
        check("R4 cas addr first", int'(a1_mcas), 3);
        check("R4 cas_oe second", int'(a2_moe), 1);
        check("R4 cas addr second", int'(a2_mcas), 3);
        check("R8 slave no cas", int'(a1_soe), 0);
        check("R4 master silent", int'(m_voe_r), 0);
        check("R6 slave vec_oe", int'(s_voe_r), 1);
        check("R6 slave vector", int'(s_vec_r), 8'h85);
        check("R6 slave int drops", int'(s_int), 0);
        s_irq = 8'h00;
        eoi(1'b1, 1'b1); cycles(2);

        // R7 non-matching slave
        s_id = 3'd6; s_irq = 8'h20; cycles(3);
        ack_pair();
        check("R7 slave silent", int'(s_voe_r), 0);
        check("R7 request pending", int'(s_int), 1);
        s_irq = 8'h00; cycles(2);
        eoi(1'b1, 1'b0); s_id = 3'd3; cycles(2);
        check("R7 quiet after", int'(m_int), 0);

        // R9 automatic end of interrupt
        m_aeoi = 1'b1; m_ext = 8'h04; cycles(2);
        ack_pair();
        check("R9 vec", int'(m_vec_r), 8'h42);
        cycles(2);
        check("R9 in-service cleared", int'(m_int), 1);
        m_ext = 8'h00; cycles(2);
        m_aeoi = 1'b0; cycles(1);

        // R12 edge capture
        m_level = 1'b0; m_ext = 8'h02; cycles(2);
        check("R12 edge sets", int'(m_int), 1);
        ack_pair();
        check("R12 vec", int'(m_vec_r), 8'h41);
        eoi(1'b1, 1'b0); cycles(2);
        check("R12 held high no re-request", int'(m_int), 0);
        m_ext = 8'h00; cycles(1);
        m_ext = 8'h02; cycles(2);
        check("R12 new edge", int'(m_int), 1);
        ack_pair();
        eoi(1'b1, 1'b0);
        m_ext = 8'h00; m_level = 1'b1; cycles(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule